// File: doc/BRIEF.md
# Segmented Window Address Translator

This block sits behind the base-address windows of a bridge port. It maps a request address that lands inside one of the port's windows into an address in a second address domain, and it names the target that owns the result. There are six windows. Each one is normally a 32-bit window. Configuration can join an even window with the odd window above it, which gives a single 64-bit window.

Each window works in one of two modes. In direct mode the whole aperture moves as a block: the offset inside the aperture is merged onto a programmed translated base. In lookup mode the aperture is cut into 32 equal slices. Only the first 24 slices can be used. Each usable slice takes its own entry from a 64-entry table that all windows share, starting at an entry index set per window. The result is registered and appears one cycle after the request strobe. It reports a hit, a miss (a window matched but no usable entry exists), or neither (no window matched).

Top module: `seg_win_xlate`

## Requirements
- R1: While rst_n is low at a clock edge, every output (out_valid, out_hit, out_miss, out_win, out_addr, out_tgt) is zero after that edge.
- R2: out_valid equals req_valid delayed by one clock. When out_valid is low, out_hit and out_miss are both low.
- R3: A 32-bit window with size field S matches when the upper 32 address bits are zero and the address bits from S upward equal the same bits of its 32-bit base. The base bits below S are ignored.
- R4: When pair bit p is set, window 2p becomes a 64-bit window. Its base is {base of window 2p+1, base of window 2p}, and its size field may be 5 to 63. Window 2p+1 then never matches.
- R5: In direct mode (mode bit 0) a hit gives out_addr = direct base OR (address offset below 2^S), and out_tgt = the window's own target value.
- R6: In lookup mode (mode bit 1) the slice number is offset >> (S-5) and the entry used is start index + slice. A hit gives out_addr = entry base OR (offset below 2^(S-5)), and out_tgt = the entry's target value.
- R7: In lookup mode, a slice number of 24 or more gives a miss.
- R8: In lookup mode, a start index + slice above 63 gives a miss.
- R9: In lookup mode, an entry whose valid bit is 0 gives a miss.
- R10: When several windows match, the lowest-numbered window is used, even if that window then misses.
- R11: A window that is disabled, or whose size field is below 5 (or above 31 when the window is not paired), never matches. When no window matches, out_hit, out_miss, out_win, out_addr and out_tgt are all zero.
- R12: On a miss, out_win holds the matched window, out_addr and out_tgt are zero, and out_hit is low. out_hit and out_miss are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Request address |
| cfg_en | input | 6 | Per-window enable |
| cfg_pair | input | 3 | Pair bit p joins windows 2p and 2p+1 |
| cfg_lookup | input | 6 | Per-window mode: 0 direct, 1 lookup |
| cfg_base | input | 192 | 32-bit base for each window, window w at bits [32w+31:32w] |
| cfg_size | input | 36 | log2 of the aperture, 6 bits per window |
| cfg_dir_base | input | 384 | 64-bit direct-mode translated base for each window |
| cfg_start | input | 36 | 6-bit start index into the table for each window |
| cfg_tgt | input | 48 | 8-bit direct-mode target for each window |
| tbl_valid | input | 64 | Valid bit for each table entry |
| tbl_base | input | 4096 | 64-bit translated slice base for each entry |
| tbl_tgt | input | 512 | 8-bit target for each entry |
| out_valid | output | 1 | Result valid, one cycle after req_valid |
| out_hit | output | 1 | Translation succeeded |
| out_miss | output | 1 | Window matched but translation failed |
| out_win | output | 3 | Index of the matched window |
| out_addr | output | 64 | Translated address |
| out_tgt | output | 8 | Target identifier |

## Verification
For each window of each configuration, the bench probes the middle of each of the 32 slices, one address just past the aperture and one just below it. A model in the bench computes the expected result with range arithmetic. The slice probes separate good entries from misses caused by an invalid entry, by the slice limit and by the table end. The probes at the edges separate a correct aperture mask from an off-by-one in the aperture size. One configuration has overlapping windows, which exposes an error in the priority order. A paired configuration places the odd window's own base where its probes would hit if that window were not silenced. A second pass with an oversized unpaired window checks that such a window is rejected.

// File: rtl/xlt_pkg.sv
// Package: shared constants and encodings for the segmented window translator.
// Assumes: the slice count per aperture is fixed at 2**SLICE_BITS.
package xlt_pkg;
    localparam int SLICE_BITS = 5;

    typedef enum logic {
        XL_DIRECT = 1'b0,
        XL_LOOKUP = 1'b1
    } xl_mode_e;
endpackage

// File: rtl/xlt_win_match.sv
// Module: decodes one base-address window against a request address.
// Gives a match flag and the offset inside the aperture.
// Assumes: a window with ROLE_HIGH=0 sits at an even index and may take the
// partner base as its upper half. A ROLE_HIGH=1 window goes silent when paired.
module xlt_win_match #(
    parameter int BASE_W    = 32,
    parameter bit ROLE_HIGH = 1'b0,
    localparam int ADDR_W   = 2 * BASE_W,
    localparam int SIZE_W   = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              win_en,
    input  logic              pair_on,
    input  logic [BASE_W-1:0] own_base,
    input  logic [BASE_W-1:0] partner_base,
    input  logic [SIZE_W-1:0] size_log2,
    output logic              match,
    output logic [ADDR_W-1:0] offset
);
    import xlt_pkg::*;

    logic              wide;
    logic              silenced;
    logic              size_ok;
    logic [ADDR_W-1:0] eff_base;
    logic [ADDR_W-1:0] span_mask;

    // Build the effective base and the aperture mask, then compare the upper bits.
    always_comb begin
        wide      = (ROLE_HIGH == 1'b0) && pair_on;
        silenced  = (ROLE_HIGH == 1'b1) && pair_on;
        eff_base  = wide ? {partner_base, own_base} : {{BASE_W{1'b0}}, own_base};
        size_ok   = (size_log2 >= SIZE_W'(SLICE_BITS)) &&
                    (wide || (size_log2 < SIZE_W'(BASE_W)));
        span_mask = (ADDR_W'(1) << size_log2) - ADDR_W'(1);
        match     = win_en && !silenced && size_ok &&
                    ((req_addr & ~span_mask) == (eff_base & ~span_mask));
        offset    = req_addr & span_mask;
    end
endmodule

// File: rtl/xlt_prio_pick.sv
// Module: fixed-priority picker. The lowest set request bit wins.
// Assumes: N is at least 2.
module xlt_prio_pick #(
    parameter int N     = 6,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] index,
    output logic             any
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        index = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                index = IDX_W'(i);
                any   = 1'b1;
            end
        end
        grant = any ? (N'(1) << index) : '0;
    end

    // Only one window may be granted.
    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R10
    end
endmodule

// File: rtl/xlt_seg_lookup.sv
// Module: lookup-mode slice translation through the shared entry table.
// Assumes: size_log2 >= SLICE_BITS whenever the result is used.
module xlt_seg_lookup #(
    parameter int ADDR_W    = 64,
    parameter int TBL_DEPTH = 64,
    parameter int SEG_LIMIT = 24,
    parameter int TGT_W     = 8,
    localparam int SIZE_W   = $clog2(ADDR_W),
    localparam int TIDX_W   = $clog2(TBL_DEPTH),
    localparam int SUM_W    = ((TIDX_W > xlt_pkg::SLICE_BITS) ? TIDX_W : xlt_pkg::SLICE_BITS) + 1
) (
    input  logic [ADDR_W-1:0]           offset,
    input  logic [SIZE_W-1:0]           size_log2,
    input  logic [TIDX_W-1:0]           start_idx,
    input  logic [TBL_DEPTH-1:0]        tbl_valid,
    input  logic [TBL_DEPTH*ADDR_W-1:0] tbl_base,
    input  logic [TBL_DEPTH*TGT_W-1:0]  tbl_tgt,
    output logic                        ok,
    output logic [ADDR_W-1:0]           seg_addr,
    output logic [TGT_W-1:0]            seg_tgt
);
    import xlt_pkg::*;

    logic [SIZE_W-1:0]     shift;
    logic [SLICE_BITS-1:0] seg;
    logic [SUM_W-1:0]      sum;
    logic [TIDX_W-1:0]     idx;
    logic                  seg_in_range;
    logic                  in_table;
    logic [ADDR_W-1:0]     low_mask;

    // Find the slice number, the table index and the range checks.
    always_comb begin
        shift        = size_log2 - SIZE_W'(SLICE_BITS);
        seg          = SLICE_BITS'(offset >> shift);
        sum          = SUM_W'(start_idx) + SUM_W'(seg);
        in_table     = sum < SUM_W'(TBL_DEPTH);
        seg_in_range = int'(seg) < SEG_LIMIT;
        idx          = TIDX_W'(sum);
        ok           = seg_in_range && in_table && tbl_valid[idx];
    end

    // Read the chosen entry and merge in the offset inside the slice.
    always_comb begin
        low_mask = (ADDR_W'(1) << shift) - ADDR_W'(1);
        seg_addr = tbl_base[int'(idx) * ADDR_W +: ADDR_W] | (offset & low_mask);
        seg_tgt  = tbl_tgt[int'(idx) * TGT_W +: TGT_W];
    end
endmodule

// File: rtl/seg_win_xlate.sv
// Module: top of the segmented window address translator.
// Decodes the windows, picks the lowest matching one, translates the address
// in direct or lookup mode, and registers the result.
// Assumes: NUM_WIN is even. The configuration is held stable while requests are in flight.
module seg_win_xlate #(
    parameter int NUM_WIN   = 6,
    parameter int BASE_W    = 32,
    parameter int TBL_DEPTH = 64,
    parameter int SEG_LIMIT = 24,
    parameter int TGT_W     = 8,
    localparam int ADDR_W   = 2 * BASE_W,
    localparam int SIZE_W   = $clog2(ADDR_W),
    localparam int TIDX_W   = $clog2(TBL_DEPTH),
    localparam int WIDX_W   = $clog2(NUM_WIN),
    localparam int NUM_PAIR = NUM_WIN / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [NUM_WIN-1:0]          cfg_en,
    input  logic [NUM_PAIR-1:0]         cfg_pair,
    input  logic [NUM_WIN-1:0]          cfg_lookup,
    input  logic [NUM_WIN*BASE_W-1:0]   cfg_base,
    input  logic [NUM_WIN*SIZE_W-1:0]   cfg_size,
    input  logic [NUM_WIN*ADDR_W-1:0]   cfg_dir_base,
    input  logic [NUM_WIN*TIDX_W-1:0]   cfg_start,
    input  logic [NUM_WIN*TGT_W-1:0]    cfg_tgt,
    input  logic [TBL_DEPTH-1:0]        tbl_valid,
    input  logic [TBL_DEPTH*ADDR_W-1:0] tbl_base,
    input  logic [TBL_DEPTH*TGT_W-1:0]  tbl_tgt,
    output logic                        out_valid,
    output logic                        out_hit,
    output logic                        out_miss,
    output logic [WIDX_W-1:0]           out_win,
    output logic [ADDR_W-1:0]           out_addr,
    output logic [TGT_W-1:0]            out_tgt
);
    import xlt_pkg::*;

    logic [NUM_WIN-1:0] win_match;
    logic [ADDR_W-1:0]  win_off [NUM_WIN];
    logic [NUM_WIN-1:0] grant;
    logic [WIDX_W-1:0]  pick_idx;
    logic               pick_any;

    // One decoder per window. Even windows can take their partner's base as the upper half.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        if ((w % 2) == 0) begin : g_lo
            xlt_win_match #(.BASE_W(BASE_W), .ROLE_HIGH(1'b0)) u_match (
                .req_addr     (req_addr),
                .win_en       (cfg_en[w]),
                .pair_on      (cfg_pair[w/2]),
                .own_base     (cfg_base[w*BASE_W +: BASE_W]),
                .partner_base (cfg_base[(w+1)*BASE_W +: BASE_W]),
                .size_log2    (cfg_size[w*SIZE_W +: SIZE_W]),
                .match        (win_match[w]),
                .offset       (win_off[w])
            );
        end else begin : g_hi
            xlt_win_match #(.BASE_W(BASE_W), .ROLE_HIGH(1'b1)) u_match (
                .req_addr     (req_addr),
                .win_en       (cfg_en[w]),
                .pair_on      (cfg_pair[w/2]),
                .own_base     (cfg_base[w*BASE_W +: BASE_W]),
                .partner_base ({BASE_W{1'b0}}),
                .size_log2    (cfg_size[w*SIZE_W +: SIZE_W]),
                .match        (win_match[w]),
                .offset       (win_off[w])
            );
        end
    end

    xlt_prio_pick #(.N(NUM_WIN)) u_pick (
        .req   (win_match),
        .grant (grant),
        .index (pick_idx),
        .any   (pick_any)
    );

    logic [ADDR_W-1:0] sel_off;
    logic [SIZE_W-1:0] sel_size;
    logic [TIDX_W-1:0] sel_start;
    logic [ADDR_W-1:0] sel_dir;
    logic [TGT_W-1:0]  sel_tgt;
    xl_mode_e          sel_mode;

    // One-hot OR-mux of the winning window's fields.
    always_comb begin
        sel_off   = '0;
        sel_size  = '0;
        sel_start = '0;
        sel_dir   = '0;
        sel_tgt   = '0;
        sel_mode  = XL_DIRECT;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (grant[w]) begin
                sel_off   = sel_off   | win_off[w];
                sel_size  = sel_size  | cfg_size[w*SIZE_W +: SIZE_W];
                sel_start = sel_start | cfg_start[w*TIDX_W +: TIDX_W];
                sel_dir   = sel_dir   | cfg_dir_base[w*ADDR_W +: ADDR_W];
                sel_tgt   = sel_tgt   | cfg_tgt[w*TGT_W +: TGT_W];
                sel_mode  = xl_mode_e'(cfg_lookup[w]);
            end
        end
    end

    logic              lk_ok;
    logic [ADDR_W-1:0] lk_addr;
    logic [TGT_W-1:0]  lk_tgt;

    xlt_seg_lookup #(
        .ADDR_W    (ADDR_W),
        .TBL_DEPTH (TBL_DEPTH),
        .SEG_LIMIT (SEG_LIMIT),
        .TGT_W     (TGT_W)
    ) u_lookup (
        .offset    (sel_off),
        .size_log2 (sel_size),
        .start_idx (sel_start),
        .tbl_valid (tbl_valid),
        .tbl_base  (tbl_base),
        .tbl_tgt   (tbl_tgt),
        .ok        (lk_ok),
        .seg_addr  (lk_addr),
        .seg_tgt   (lk_tgt)
    );

    // Register the outcome one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_miss  <= 1'b0;
            out_win   <= '0;
            out_addr  <= '0;
            out_tgt   <= '0;
        end else begin
            out_valid <= req_valid;
            out_hit   <= 1'b0;
            out_miss  <= 1'b0;
            out_win   <= '0;
            out_addr  <= '0;
            out_tgt   <= '0;
            if (req_valid && pick_any) begin
                out_win <= pick_idx;
                if (sel_mode == XL_DIRECT) begin
                    out_hit  <= 1'b1;
                    out_addr <= sel_dir | sel_off;
                    out_tgt  <= sel_tgt;
                end else if (lk_ok) begin
                    out_hit  <= 1'b1;
                    out_addr <= lk_addr;
                    out_tgt  <= lk_tgt;
                end else begin
                    out_miss <= 1'b1;
                end
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_hit && !out_miss && out_addr == '0)); // R1
    AST_RESULT_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_hit && !out_miss)); // R2
    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hit && out_miss)); // R12
    AST_MISS_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_addr == '0 && out_tgt == '0)); // R12
endmodule

// File: tb/seg_win_xlate_test.sv
// Bench: sweeps slice probes over every window of three configurations and
// compares each result with an arithmetic model of the requirements.
module seg_win_xlate_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [63:0]   req_addr = '0;
    logic [5:0]    cfg_en = '0;
    logic [2:0]    cfg_pair = '0;
    logic [5:0]    cfg_lookup = '0;
    logic [191:0]  cfg_base = '0;
    logic [35:0]   cfg_size = '0;
    logic [383:0]  cfg_dir_base = '0;
    logic [35:0]   cfg_start = '0;
    logic [47:0]   cfg_tgt = '0;
    logic [63:0]   tbl_valid = '0;
    logic [4095:0] tbl_base = '0;
    logic [511:0]  tbl_tgt = '0;
    logic          out_valid, out_hit, out_miss;
    logic [2:0]    out_win;
    logic [63:0]   out_addr;
    logic [7:0]    out_tgt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    seg_win_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cfg_en(cfg_en), .cfg_pair(cfg_pair), .cfg_lookup(cfg_lookup),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_dir_base(cfg_dir_base),
        .cfg_start(cfg_start), .cfg_tgt(cfg_tgt), .tbl_valid(tbl_valid),
        .tbl_base(tbl_base), .tbl_tgt(tbl_tgt), .out_valid(out_valid),
        .out_hit(out_hit), .out_miss(out_miss), .out_win(out_win),
        .out_addr(out_addr), .out_tgt(out_tgt)
    );

    task automatic set_win(input int w, input bit en, input bit lk, input logic [31:0] b,
                           input int sz, input logic [63:0] dir, input int st, input int tg);
        cfg_en[w] = en;
        cfg_lookup[w] = lk;
        cfg_base[w*32 +: 32] = b;
        cfg_size[w*6 +: 6] = 6'(sz);
        cfg_dir_base[w*64 +: 64] = dir;
        cfg_start[w*6 +: 6] = 6'(st);
        cfg_tgt[w*8 +: 8] = 8'(tg);
    endtask

    // Base and aperture of window w as the bench sees it (paired or not).
    task automatic win_geom(input int w, output logic [64:0] b0, output logic [64:0] ap,
                            output bit wide);
        logic [64:0] base;
        wide = (w % 2 == 0) && cfg_pair[w/2];
        base = wide ? {1'b0, cfg_base[(w+1)*32 +: 32], cfg_base[w*32 +: 32]}
                    : {33'b0, cfg_base[w*32 +: 32]};
        ap = 65'd1 << cfg_size[w*6 +: 6];
        b0 = (base / ap) * ap;
    endtask

    // Expected result from the requirements, by range arithmetic.
    task automatic model(input logic [63:0] a, output bit eh, output bit em, output int ew,
                         output logic [63:0] ex, output logic [7:0] et, output string tag);
        int nmatch = 0;
        eh = 0; em = 0; ew = 0; ex = '0; et = '0; tag = "R11";
        for (int w = 0; w < 6; w++) begin
            logic [64:0] b0, ap, off, slc;
            bit wide;
            int sz, seg, ent;
            win_geom(w, b0, ap, wide);
            sz = int'(cfg_size[w*6 +: 6]);
            if (!cfg_en[w]) continue;
            if ((w % 2 == 1) && cfg_pair[w/2]) continue;
            if (sz < 5 || (!wide && sz > 31)) continue;
            if (!({1'b0, a} >= b0 && {1'b0, a} < b0 + ap)) continue;
            nmatch++;
            if (nmatch > 1) begin
                tag = "R10";
                continue;
            end
            ew = w;
            off = {1'b0, a} - b0;
            if (!cfg_lookup[w]) begin
                eh = 1; ex = cfg_dir_base[w*64 +: 64] | off[63:0]; et = cfg_tgt[w*8 +: 8];
                tag = wide ? "R4" : "R5";
            end else begin
                slc = ap / 32;
                seg = int'(off / slc);
                ent = int'(cfg_start[w*6 +: 6]) + seg;
                if (seg >= 24) begin em = 1; tag = "R7"; end
                else if (ent > 63) begin em = 1; tag = "R8"; end
                else if (!tbl_valid[ent]) begin em = 1; tag = "R9"; end
                else begin
                    eh = 1; tag = wide ? "R4" : "R6";
                    ex = tbl_base[ent*64 +: 64] | 64'(off % slc);
                    et = tbl_tgt[ent*8 +: 8];
                end
            end
        end
        if (em) tag = {tag, "/R12"};
        else if (!eh) tag = {tag, "/R3"};
    endtask

    task automatic do_req(input logic [63:0] a);
        bit eh, em;
        int ew;
        logic [63:0] ex;
        logic [7:0] et;
        string tag;
        req_valid = 1'b1;
        req_addr = a;
        model(a, eh, em, ew, ex, et, tag);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || out_hit !== eh || out_miss !== em || int'(out_win) != ew ||
            out_addr !== ex || out_tgt !== et) begin
            errors++;
            $display("FAIL %s addr=%h got v=%0b h=%0b m=%0b w=%0d x=%h t=%h exp v=1 h=%0b m=%0b w=%0d x=%h t=%h",
                     tag, a, out_valid, out_hit, out_miss, out_win, out_addr, out_tgt,
                     eh, em, ew, ex, et);
        end
    endtask

    task automatic check_idle(input string tag);
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_hit !== 1'b0 || out_miss !== 1'b0 || out_addr !== '0) begin
            errors++;
            $display("FAIL %s idle got v=%0b h=%0b m=%0b x=%h exp v=0 h=0 m=0 x=0",
                     tag, out_valid, out_hit, out_miss, out_addr);
        end
    endtask

    // Probe every slice midpoint, the address just past the aperture and the one just below it.
    task automatic sweep();
        for (int w = 0; w < 6; w++) begin
            logic [64:0] b0, ap;
            bit wide;
            win_geom(w, b0, ap, wide);
            for (int k = 0; k < 34; k++) begin
                logic [64:0] a;
                if (k < 32) a = b0 + 65'(k) * (ap / 32) + (ap / 64) + 65'(k % 3);
                else if (k == 32) a = b0 + ap;
                else a = b0 - 65'd1;
                do_req(a[63:0]);
            end
        end
        check_idle("R2");
    endtask

    initial begin
        for (int e = 0; e < 64; e++) begin
            tbl_valid[e] = (e % 7) != 0;
            tbl_base[e*64 +: 64] = 64'(e + 1) << 40;
            tbl_tgt[e*8 +: 8] = 8'(e + 16);
        end
        // Config A: six 32-bit windows with an overlap, limits and rejected windows.
        set_win(0, 1, 0, 32'h1000_0000, 12, 64'h0000_000A_0000_0000, 0, 8'h01);
        set_win(1, 1, 1, 32'h2000_0000, 10, 64'h0, 0, 8'h02);
        set_win(2, 1, 0, 32'h2000_0000, 16, 64'h0000_00BB_0000_0000, 0, 8'h03);
        set_win(3, 1, 1, 32'h3000_0000, 8, 64'h0, 50, 8'h04);
        set_win(4, 0, 0, 32'h4000_0000, 12, 64'h0000_00CC_0000_0000, 0, 8'h05);
        set_win(5, 1, 0, 32'h5000_0000, 4, 64'h0000_00DD_0000_0000, 0, 8'h06);
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_hit !== 0 || out_miss !== 0 || out_win !== 0 ||
            out_addr !== 0 || out_tgt !== 0) begin
            errors++;
            $display("FAIL R1 reset got v=%0b h=%0b m=%0b w=%0d x=%h t=%h exp all 0",
                     out_valid, out_hit, out_miss, out_win, out_addr, out_tgt);
        end
        req_valid = 1'b0;
        rst_n = 1'b1;
        check_idle("R2");
        sweep();
        // Oversized window that is not paired must be rejected (R11).
        set_win(5, 1, 0, 32'h5000_0000, 40, 64'h0000_00DD_0000_0000, 0, 8'h06);
        sweep();
        // Config B: pairs 0 and 2 joined, pair 1 separate and overlapping.
        cfg_pair = 3'b101;
        set_win(0, 1, 1, 32'h0000_0000, 34, 64'h0, 8, 8'h10);
        set_win(1, 1, 0, 32'h0000_0040, 12, 64'h0000_00EE_0000_0000, 0, 8'h11);
        set_win(2, 1, 0, 32'h0000_8000, 15, 64'hFFFF_0000_0000_0000, 0, 8'h22);
        set_win(3, 1, 1, 32'h0001_0000, 31, 64'h0, 60, 8'h33);
        set_win(4, 1, 0, 32'h0000_0000, 20, 64'h0000_1234_0000_0000, 0, 8'h45);
        set_win(5, 1, 0, 32'h8000_0000, 8, 64'h0000_00FF_0000_0000, 0, 8'h46);
        sweep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule